// File: doc/BRIEF.md
# Fault-Triggered Output Shutdown and Pin Enable Controller

This block sits between a four-channel waveform generator and its output pins. It watches one of several active-low fault lines, picked by a select input, and a software shutdown request. When either becomes active, it latches a shutdown status and drives every pin to a shutdown level programmed for that pin. The level can be driven low, driven high, released to high impedance, or the inactive level of the pin's normal polarity.

The shutdown ends in one of two ways. In manual mode, software must clear it, and a clear is refused while the synchronized fault is still low. In auto-restart mode, the status drops on the first rising edge of the restart reference waveform (lane 0) seen while the fault is high. The outputs resume from that edge.

A per-pin enable disconnects a pin from the whole path. A per-pin override substitutes a fixed value for the waveform. The fixed priority order is shutdown, then override, then waveform.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset `sd_status_o` is 0 and each enabled, non-overridden pin drives `wave_i[k] ^ pol_i[k]` with `pin_oe_o[k]` = 1.
- R2: Only the source at index `fault_sel_i` of `fault_n_i` triggers shutdown. It passes through a two-stage synchronizer, so `sd_status_o` rises at the third rising clock edge after that source goes low. A low level on any other source has no effect.
- R3: A `sw_set_i` pulse sampled at a rising edge sets `sd_status_o` at that edge, whatever the fault level.
- R4: While `sd_status_o` is 1, enabled lane k takes its shutdown code from `sd_state_i[2k+1:2k]`. The codes are: 2'b00 drives `pol_i[k]` with oe 1; 2'b01 gives oe 0 and pin 0; 2'b10 drives 0 with oe 1; 2'b11 drives 1 with oe 1.
- R5: With `auto_restart_i` = 0, `sd_status_o` stays 1 until a `sw_clr_i` pulse is sampled while the synchronized fault is high. It then clears at that edge.
- R6: A `sw_clr_i` pulse sampled while the synchronized fault is low leaves `sd_status_o` at 1.
- R7: With `auto_restart_i` = 1 and the synchronized fault high, `sd_status_o` clears at the first edge where `wave_i[0]` is 1 after being 0 at the previous edge. The pins return to the waveform path from then on.
- R8: With `out_en_i[k]` = 0, `pin_oe_o[k]` and `pin_o[k]` are 0, whatever else is applied.
- R9: Outside shutdown, an enabled lane with `ovr_en_i[k]` = 1 drives `ovr_val_i[k]`. Otherwise it drives `wave_i[k] ^ pol_i[k]`. Shutdown overrides both.
- R10: When `sw_set_i` and `sw_clr_i` are sampled in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wave_i | input | 4 | Waveform from the generator; bit 0 is the restart reference |
| pol_i | input | 4 | Normal polarity per lane (1 = inverted) |
| fault_n_i | input | 4 | Active-low fault sources |
| fault_sel_i | input | 2 | Index of the monitored fault source |
| sd_state_i | input | 8 | Two-bit shutdown code per lane |
| sw_set_i | input | 1 | Software shutdown request |
| sw_clr_i | input | 1 | Software shutdown clear |
| auto_restart_i | input | 1 | 1 = automatic exit on reference edge |
| out_en_i | input | 4 | Per-lane pin connection enable |
| ovr_en_i | input | 4 | Per-lane override enable |
| ovr_val_i | input | 4 | Per-lane override value |
| pin_o | output | 4 | Pin drive value |
| pin_oe_o | output | 4 | Pin drive enable |
| sd_status_o | output | 1 | Shutdown status |

## Verification
The bench applies each stimulus after a falling edge and compares at the next falling edge.

- Software set and clear, and the auto-restart edge, show in `sd_status_o` one rising edge after they are applied.
- A selected fault shows three rising edges after it falls, and its release gates a clear only after the same two-edge synchronizer delay.
- Pin values follow status and inputs without further delay, so they are compared in the same window as the status.

A bench reference model steps once per rising edge and carries the synchronizer and reference-edge history. It therefore produces the expected value for exactly the sampled cycle, in both the directed corner cases and the seeded random run.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    SD_INACTIVE = 2'b00,
    SD_TRISTATE = 2'b01,
    SD_LOW      = 2'b10,
    SD_HIGH     = 2'b11
  } sd_mode_e;
endpackage

// File: rtl/pfg_fault_sync.sv
module pfg_fault_sync #(
  parameter int NSRC   = 4,
  parameter int SEL_W  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  fault_n_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             fault_low_o
);
  logic              sel_n;
  logic [STAGES-1:0] chain_q;

  // out-of-range select reads as no fault
  always_comb begin
    sel_n = 1'b1;
    for (int i = 0; i < NSRC; i++)
      if (sel_i == SEL_W'(i)) sel_n = fault_n_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], ~sel_n};
  end

  assign fault_low_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfg_sd_ctrl.sv
module pfg_sd_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_low_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic auto_restart_i,
  input  logic restart_ref_i,
  output logic sd_o
);
  logic ref_q;
  logic ref_rise;
  logic sd_d;

  assign ref_rise = restart_ref_i & ~ref_q;

  always_comb begin
    sd_d = sd_o;
    if (sw_set_i || fault_low_i)               sd_d = 1'b1;
    else if (sw_clr_i)                         sd_d = 1'b0;
    else if (auto_restart_i && ref_rise)       sd_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_o  <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      sd_o  <= sd_d;
      ref_q <= restart_ref_i;
    end
  end

  a_r3_sw_set_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_set_i |=> sd_o);
  a_r2_fault_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_low_i |=> sd_o);
  a_r6_clr_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_o && fault_low_i) |=> sd_o);
  a_r5_manual_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_o && !auto_restart_i && !sw_clr_i) |=> sd_o);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_set_i && sw_clr_i) |=> sd_o);
endmodule

// File: rtl/pfg_pin_lane.sv
module pfg_pin_lane
  import pfg_pkg::*;
(
  input  logic     wave_i,
  input  logic     pol_i,
  input  logic     en_i,
  input  logic     ovr_en_i,
  input  logic     ovr_val_i,
  input  logic     sd_i,
  input  sd_mode_e mode_i,
  output logic     pin_o,
  output logic     oe_o
);
  always_comb begin
    pin_o = 1'b0;
    oe_o  = 1'b0;
    if (en_i) begin
      oe_o = 1'b1;
      if (sd_i) begin
        unique case (mode_i)
          SD_INACTIVE: pin_o = pol_i;
          SD_TRISTATE: oe_o  = 1'b0;
          SD_LOW:      pin_o = 1'b0;
          SD_HIGH:     pin_o = 1'b1;
          default:     pin_o = 1'b0;
        endcase
      end else if (ovr_en_i) begin
        pin_o = ovr_val_i;
      end else begin
        pin_o = wave_i ^ pol_i;
      end
    end
  end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pfg_pkg::*;
#(
  parameter int NOUT         = 4,
  parameter int NSRC         = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int RESTART_LANE = 0,
  localparam int SelW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NOUT-1:0]   wave_i,
  input  logic [NOUT-1:0]   pol_i,
  input  logic [NSRC-1:0]   fault_n_i,
  input  logic [SelW-1:0]   fault_sel_i,
  input  logic [2*NOUT-1:0] sd_state_i,
  input  logic              sw_set_i,
  input  logic              sw_clr_i,
  input  logic              auto_restart_i,
  input  logic [NOUT-1:0]   out_en_i,
  input  logic [NOUT-1:0]   ovr_en_i,
  input  logic [NOUT-1:0]   ovr_val_i,
  output logic [NOUT-1:0]   pin_o,
  output logic [NOUT-1:0]   pin_oe_o,
  output logic              sd_status_o
);
  logic fault_low;

  pfg_fault_sync #(
    .NSRC  (NSRC),
    .SEL_W (SelW),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fault_n_i  (fault_n_i),
    .sel_i      (fault_sel_i),
    .fault_low_o(fault_low)
  );

  pfg_sd_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fault_low_i   (fault_low),
    .sw_set_i      (sw_set_i),
    .sw_clr_i      (sw_clr_i),
    .auto_restart_i(auto_restart_i),
    .restart_ref_i (wave_i[RESTART_LANE]),
    .sd_o          (sd_status_o)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_lane
    pfg_pin_lane u_lane (
      .wave_i   (wave_i[g]),
      .pol_i    (pol_i[g]),
      .en_i     (out_en_i[g]),
      .ovr_en_i (ovr_en_i[g]),
      .ovr_val_i(ovr_val_i[g]),
      .sd_i     (sd_status_o),
      .mode_i   (sd_mode_e'(sd_state_i[2*g +: 2])),
      .pin_o    (pin_o[g]),
      .oe_o     (pin_oe_o[g])
    );

    a_r8_lane_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_en_i[g] |-> (!pin_oe_o[g] && !pin_o[g]));
    a_r4_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sd_status_o && sd_state_i[2*g +: 2] == 2'b01) |-> !pin_oe_o[g]);
    a_r9_no_sd_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sd_status_o && out_en_i[g]) |-> pin_oe_o[g]);
  end
endmodule

// File: tb/pwm_fault_guard_bench.sv
module pwm_fault_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] wave = '0, pol = '0, fault_n = '1, out_en = '1, ovr_en = '0, ovr_val = '0;
  logic [1:0] fsel = '0;
  logic [7:0] sd_state = '0;
  logic       sw_set = 1'b0, sw_clr = 1'b0, auto_rs = 1'b0;
  logic [3:0] pin, pin_oe;
  logic       sd_status;

  int n_chk = 0, n_bad = 0;
  logic m_s1 = 0, m_s2 = 0, m_sd = 0, m_ref = 0;

  always #10ns clk = ~clk;

  pwm_fault_guard u_pwm_fault_guard (
    .clk_i(clk), .rst_ni(rst_n), .wave_i(wave), .pol_i(pol), .fault_n_i(fault_n),
    .fault_sel_i(fsel), .sd_state_i(sd_state), .sw_set_i(sw_set), .sw_clr_i(sw_clr),
    .auto_restart_i(auto_rs), .out_en_i(out_en), .ovr_en_i(ovr_en), .ovr_val_i(ovr_val),
    .pin_o(pin), .pin_oe_o(pin_oe), .sd_status_o(sd_status)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // expected {oe,pin} for lane k from the requirements
  function automatic logic [1:0] exp_lane(input int k);
    if (!out_en[k]) return 2'b00;                           // R8
    if (m_sd) case (sd_state[2*k +: 2])                     // R4
      2'b00: return {1'b1, pol[k]};
      2'b01: return 2'b00;
      2'b10: return 2'b10;
      default: return 2'b11;
    endcase
    if (ovr_en[k]) return {1'b1, ovr_val[k]};               // R9
    return {1'b1, wave[k] ^ pol[k]};
  endfunction

  task automatic model_check();
    chk("R2 status", {1'b0, sd_status}, {1'b0, m_sd});
    for (int k = 0; k < 4; k++)
      chk(!out_en[k] ? "R8 lane" : (m_sd ? "R4 lane" : "R9 lane"),
          {pin_oe[k], pin[k]}, exp_lane(k));
  endtask

  task automatic tick();
    logic nxt;
    @(posedge clk);
    nxt = m_sd;
    if (sw_set || m_s2)               nxt = 1'b1;
    else if (sw_clr)                  nxt = 1'b0;
    else if (auto_rs && wave[0] && !m_ref) nxt = 1'b0;
    m_sd = nxt;
    m_ref = wave[0];
    m_s2 = m_s1;
    m_s1 = ~fault_n[fsel];
    @(negedge clk);
    sw_set = 1'b0;
    sw_clr = 1'b0;
    model_check();
  endtask

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    pol = 4'b0101; wave = 4'b0011;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", {1'b0, sd_status}, 2'b00);
    chk("R1 pins", {pin[1], pin[0]}, {wave[1]^pol[1], wave[0]^pol[0]});
    // unselected source low
    fsel = 2'd1; fault_n = 4'b1110;
    repeat (4) tick();
    chk("R2 unselected", {1'b0, sd_status}, 2'b00);
    // selected source low: third edge
    fault_n = 4'b1100;
    tick(); tick();
    chk("R2 before sync", {1'b0, sd_status}, 2'b00);
    tick();
    chk("R2 entered", {1'b0, sd_status}, 2'b01);
    sd_state = {2'b11, 2'b10, 2'b01, 2'b00};
    #1ns;
    chk("R4 inactive", {pin_oe[0], pin[0]}, 2'b11);
    chk("R4 tristate", {pin_oe[1], pin[1]}, 2'b00);
    chk("R4 low", {pin_oe[2], pin[2]}, 2'b10);
    chk("R4 high", {pin_oe[3], pin[3]}, 2'b11);
    sw_clr = 1'b1; tick();
    chk("R6 clr blocked", {1'b0, sd_status}, 2'b01);
    fault_n = 4'b1111;
    repeat (4) tick();
    chk("R5 held", {1'b0, sd_status}, 2'b01);
    sw_clr = 1'b1; tick();
    chk("R5 cleared", {1'b0, sd_status}, 2'b00);
    sw_set = 1'b1; tick();
    chk("R3 sw set", {1'b0, sd_status}, 2'b01);
    sw_set = 1'b1; sw_clr = 1'b1; tick();
    chk("R10 set wins", {1'b0, sd_status}, 2'b01);
    auto_rs = 1'b1; wave = 4'b0000; tick();
    chk("R7 waiting", {1'b0, sd_status}, 2'b01);
    tick();
    chk("R7 still waiting", {1'b0, sd_status}, 2'b01);
    wave = 4'b0001; tick();
    chk("R7 restarted", {1'b0, sd_status}, 2'b00);
    chk("R7 resume", {pin_oe[0], pin[0]}, {1'b1, 1'b1 ^ pol[0]});
    out_en = 4'b1100; ovr_en = 4'b1000; ovr_val = 4'b1000; wave = 4'b0000;
    #1ns;
    chk("R8 off", {pin_oe[1:0], pin[1:0]}, 4'b0000);
    chk("R9 override", {pin_oe[3], pin[3]}, 2'b11);
    chk("R9 wave", {pin_oe[2], pin[2]}, {1'b1, pol[2]});
    // seeded random phase
    for (int i = 0; i < 3000; i++) begin
      wave    = 4'($urandom);
      fault_n = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
      if ($urandom % 16 == 0) fsel = 2'($urandom);
      if ($urandom % 64 == 0) auto_rs = ~auto_rs;
      if ($urandom % 32 == 0) begin pol = 4'($urandom); sd_state = 8'($urandom); end
      out_en  = 4'($urandom) | 4'($urandom);
      ovr_en  = 4'($urandom) & 4'($urandom);
      ovr_val = 4'($urandom);
      sw_set  = ($urandom % 40 == 0);
      sw_clr  = ($urandom % 10 == 0);
      tick();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule